// File: doc/BRIEF.md
# Audio Receiver Output Clock and Status Router

This block is the last stage of a digital audio interface receiver. From a master clock running at 256 times the sample rate it derives a bit clock (64fs), a word clock (fs) and an auxiliary clock (128fs) for external converters. It sends each decoded 24-bit sample as a 32-bit slot twice: once on an external serial data pin and once on an internal serial path to a downstream DSP. The two paths mute under different conditions.

Four output pins are shared. Each has a mode input that picks either its default signal (auxiliary clock, frame sync pulse, error flag, double-rate flag) or one of the per-subframe status bits: channel status, user data, block start or validity. Status bits are captured once per subframe and held for the whole slot. A free-running receiver, or a status mute input, forces them low. The frame decoder, clock recovery and control registers lie outside the block and drive it through plain inputs.

Top module: `aud_rx_out_router`

## Requirements
- R1: With the count of master cycles since reset at c, bck_o = c[1], wck_o = c[7] and aux clock = c[0]. So bit clock = master/4, word clock = master/256, auxiliary clock = master/2, and the word and bit clocks fall together at each frame start.
- R2: In a slot, bit position b = c[6:2] carries sample bit 23-b for b < 24 and zero for b = 24..31 (MSB first). The data changes only where the bit clock falls. The left slot is sent while wck_o is low and the right slot while it is high.
- R3: The sample for each slot is taken from sample_l_i (left) or sample_r_i (right) in the last master cycle before that slot starts. After reset the first left slot carries zero.
- R4: sdo_o is 0 whenever free_run_i or sdo_mute_i is 1.
- R5: dsp_sdo_o is 0 whenever free_run_i is 1. sdo_mute_i has no effect on it: with free_run_i low it equals the unmuted slot data.
- R6: fs128_c_o carries the auxiliary clock when cs_mode_i = 0 and the latched channel-status bit when cs_mode_i = 1.
- R7: sync_u_o carries a sync pulse when user_mode_i = 0. The pulse is high for the first bit period (four master cycles) of each left slot. When user_mode_i = 1 it carries the latched user bit.
- R8: err_bs_o passes err_flag_i when bs_mode_i = 0 and carries the latched block-start bit when bs_mode_i = 1.
- R9: dbl_v_o passes dbl_flag_i when val_mode_i = 0 and carries the latched validity bit when val_mode_i = 1.
- R10: Any pin that has a status bit selected is 0 while free_run_i or vuc_mute_i is 1. Pins that carry clocks or flags are not affected by these mutes.
- R11: Status bits are captured with the same timing as the sample (index 0 = left, 1 = right; blk_start_i is used for both slots). They hold for the whole slot.
- R12: In reset, bck_o, wck_o, sdo_o and dsp_sdo_o are 0, the auxiliary clock is 0 and the sync pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256fs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_run_i | input | 1 | Receiver unlocked, free-running |
| sdo_mute_i | input | 1 | Mute for the external serial pin only |
| vuc_mute_i | input | 1 | Mute for status bits on the shared pins |
| cs_mode_i | input | 1 | Selects channel status on fs128_c_o |
| user_mode_i | input | 1 | Selects user data on sync_u_o |
| bs_mode_i | input | 1 | Selects block start on err_bs_o |
| val_mode_i | input | 1 | Selects validity on dbl_v_o |
| err_flag_i | input | 1 | Error flag passed through when not in status mode |
| dbl_flag_i | input | 1 | Double-rate flag passed through when not in status mode |
| sample_l_i | input | 24 | Left sample |
| sample_r_i | input | 24 | Right sample |
| blk_start_i | input | 1 | Block start indication |
| valid_i | input | 2 | Validity per subframe (0 left, 1 right) |
| user_i | input | 2 | User bit per subframe |
| chan_i | input | 2 | Channel-status bit per subframe |
| bck_o | output | 1 | Bit clock, 64fs |
| wck_o | output | 1 | Word clock, fs |
| fs128_c_o | output | 1 | Auxiliary clock or channel status |
| sync_u_o | output | 1 | Sync pulse or user bit |
| err_bs_o | output | 1 | Error flag or block start |
| dbl_v_o | output | 1 | Double-rate flag or validity |
| sdo_o | output | 1 | External serial data |
| dsp_sdo_o | output | 1 | Internal serial data to the DSP |

## Verification
At every slot boundary four things happen in one master cycle: the shift register reloads, the status bits are captured, the word clock toggles and the bit clock falls. At the left boundary the sync pulse also starts. The bench drives new samples and status bits mid-frame and records what the design should have captured one cycle before each boundary. It then checks every output at every master cycle across all combinations of the four pin modes and the three mute sources. A stale or early capture would show as a wrong bit in the first cycle of the new slot.

// File: rtl/aud_rx_out_pkg.sv
package aud_rx_out_pkg;
  typedef struct packed {
    logic bs;
    logic v;
    logic u;
    logic c;
  } sub_stat_t;
endpackage

// File: rtl/aud_rx_clk_div.sv
module aud_rx_clk_div #(
  parameter int BCK_DIV = 4,
  parameter int SLOT_W  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bck_o,
  output logic wck_o,
  output logic aux_o,
  output logic sync_o,
  output logic load_o,
  output logic shift_o,
  output logic next_slot_o
);
  localparam int BCK_LOG  = $clog2(BCK_DIV);
  localparam int SLOT_LOG = $clog2(SLOT_W);
  localparam int CNT_W    = BCK_LOG + SLOT_LOG + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign bck_o       = cnt_q[BCK_LOG-1];
  assign aux_o       = cnt_q[BCK_LOG-2];
  assign wck_o       = cnt_q[CNT_W-1];
  assign sync_o      = (cnt_q[CNT_W-1:BCK_LOG] == '0);
  // last master cycle of a slot: reload and capture for the next one
  assign load_o      = &cnt_q[CNT_W-2:0];
  assign next_slot_o = ~cnt_q[CNT_W-1];
  assign shift_o     = (&cnt_q[BCK_LOG-1:0]) & ~load_o;
endmodule

// File: rtl/aud_rx_ser.sv
module aud_rx_ser #(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              next_slot_i,
  input  logic [DATA_W-1:0] sample_l_i,
  input  logic [DATA_W-1:0] sample_r_i,
  input  logic              free_run_i,
  input  logic              sdo_mute_i,
  output logic              sdo_o,
  output logic              dsp_o
);
  logic [SLOT_W-1:0] sh_q;
  logic [SLOT_W-1:0] ld_word;
  logic [DATA_W-1:0] pick;

  assign pick = next_slot_i ? sample_r_i : sample_l_i;

  generate
    if (SLOT_W > DATA_W) begin : g_pad
      assign ld_word = {pick, {(SLOT_W-DATA_W){1'b0}}};
    end else begin : g_nopad
      assign ld_word = pick;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= ld_word;
    else if (shift_i) sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
  end

  assign sdo_o = sh_q[SLOT_W-1] & ~(free_run_i | sdo_mute_i);
  assign dsp_o = sh_q[SLOT_W-1] & ~free_run_i;
endmodule

// File: rtl/aud_rx_stat_lat.sv
module aud_rx_stat_lat
  import aud_rx_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       next_slot_i,
  input  logic       blk_start_i,
  input  logic [1:0] valid_i,
  input  logic [1:0] user_i,
  input  logic [1:0] chan_i,
  output sub_stat_t  stat_o
);
  sub_stat_t nxt;

  always_comb begin
    nxt.bs = blk_start_i;
    nxt.v  = valid_i[next_slot_i];
    nxt.u  = user_i[next_slot_i];
    nxt.c  = chan_i[next_slot_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_o <= '0;
    else if (load_i) stat_o <= nxt;
  end
endmodule

// File: rtl/aud_rx_pin_mux.sv
module aud_rx_pin_mux
  import aud_rx_out_pkg::*;
(
  input  sub_stat_t stat_i,
  input  logic      free_run_i,
  input  logic      vuc_mute_i,
  input  logic      cs_mode_i,
  input  logic      user_mode_i,
  input  logic      bs_mode_i,
  input  logic      val_mode_i,
  input  logic      aux_i,
  input  logic      sync_i,
  input  logic      err_flag_i,
  input  logic      dbl_flag_i,
  output logic      fs128_c_o,
  output logic      sync_u_o,
  output logic      err_bs_o,
  output logic      dbl_v_o
);
  sub_stat_t gated;

  assign gated = (free_run_i | vuc_mute_i) ? '0 : stat_i;

  assign fs128_c_o = cs_mode_i   ? gated.c  : aux_i;
  assign sync_u_o  = user_mode_i ? gated.u  : sync_i;
  assign err_bs_o  = bs_mode_i   ? gated.bs : err_flag_i;
  assign dbl_v_o   = val_mode_i  ? gated.v  : dbl_flag_i;
endmodule

// File: rtl/aud_rx_out_router.sv
module aud_rx_out_router
  import aud_rx_out_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SLOT_W  = 32,
  parameter int BCK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_run_i,
  input  logic              sdo_mute_i,
  input  logic              vuc_mute_i,
  input  logic              cs_mode_i,
  input  logic              user_mode_i,
  input  logic              bs_mode_i,
  input  logic              val_mode_i,
  input  logic              err_flag_i,
  input  logic              dbl_flag_i,
  input  logic [DATA_W-1:0] sample_l_i,
  input  logic [DATA_W-1:0] sample_r_i,
  input  logic              blk_start_i,
  input  logic [1:0]        valid_i,
  input  logic [1:0]        user_i,
  input  logic [1:0]        chan_i,
  output logic              bck_o,
  output logic              wck_o,
  output logic              fs128_c_o,
  output logic              sync_u_o,
  output logic              err_bs_o,
  output logic              dbl_v_o,
  output logic              sdo_o,
  output logic              dsp_sdo_o
);
  logic      aux, sync, load, shift, next_slot;
  sub_stat_t stat;

  aud_rx_clk_div #(.BCK_DIV(BCK_DIV), .SLOT_W(SLOT_W)) i_clk_div (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bck_o(bck_o), .wck_o(wck_o), .aux_o(aux), .sync_o(sync),
    .load_o(load), .shift_o(shift), .next_slot_o(next_slot)
  );

  aud_rx_ser #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .shift_i(shift), .next_slot_i(next_slot),
    .sample_l_i(sample_l_i), .sample_r_i(sample_r_i),
    .free_run_i(free_run_i), .sdo_mute_i(sdo_mute_i),
    .sdo_o(sdo_o), .dsp_o(dsp_sdo_o)
  );

  aud_rx_stat_lat i_stat_lat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .next_slot_i(next_slot),
    .blk_start_i(blk_start_i), .valid_i(valid_i),
    .user_i(user_i), .chan_i(chan_i),
    .stat_o(stat)
  );

  aud_rx_pin_mux i_pin_mux (
    .stat_i(stat), .free_run_i(free_run_i), .vuc_mute_i(vuc_mute_i),
    .cs_mode_i(cs_mode_i), .user_mode_i(user_mode_i),
    .bs_mode_i(bs_mode_i), .val_mode_i(val_mode_i),
    .aux_i(aux), .sync_i(sync),
    .err_flag_i(err_flag_i), .dbl_flag_i(dbl_flag_i),
    .fs128_c_o(fs128_c_o), .sync_u_o(sync_u_o),
    .err_bs_o(err_bs_o), .dbl_v_o(dbl_v_o)
  );
endmodule

// File: rtl/aud_rx_out_router_chk.sv
module aud_rx_out_router_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic free_run_i,
  input logic sdo_mute_i,
  input logic vuc_mute_i,
  input logic cs_mode_i,
  input logic bs_mode_i,
  input logic bck_o,
  input logic wck_o,
  input logic fs128_c_o,
  input logic err_bs_o,
  input logic sdo_o,
  input logic dsp_sdo_o
);
  AST_FRAME_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wck_o) |-> $fell(bck_o)); // R1

  AST_DATA_ON_BCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$fell(bck_o) && $stable(free_run_i)) |-> $stable(dsp_sdo_o)); // R2

  AST_SDO_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_run_i || sdo_mute_i) |-> !sdo_o); // R4

  AST_DSP_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i |-> !dsp_sdo_o); // R5

  AST_PATHS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && !sdo_mute_i) |-> (sdo_o == dsp_sdo_o)); // R5

  AST_CS_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_mode_i && (free_run_i || vuc_mute_i)) |-> !fs128_c_o); // R10

  AST_BS_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs_mode_i && (free_run_i || vuc_mute_i)) |-> !err_bs_o); // R10

  AST_CS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_mode_i && $stable(cs_mode_i) && $stable(free_run_i) &&
     $stable(vuc_mute_i) && $stable(wck_o)) |-> $stable(fs128_c_o)); // R11
endmodule

bind aud_rx_out_router aud_rx_out_router_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .free_run_i(free_run_i),
  .sdo_mute_i(sdo_mute_i), .vuc_mute_i(vuc_mute_i),
  .cs_mode_i(cs_mode_i), .bs_mode_i(bs_mode_i),
  .bck_o(bck_o), .wck_o(wck_o), .fs128_c_o(fs128_c_o),
  .err_bs_o(err_bs_o), .sdo_o(sdo_o), .dsp_sdo_o(dsp_sdo_o)
);

// File: tb/test_aud_rx_out_router.sv
module test_aud_rx_out_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        free_run_i = 0, sdo_mute_i = 0, vuc_mute_i = 0;
  logic        cs_mode_i = 0, user_mode_i = 0, bs_mode_i = 0, val_mode_i = 0;
  logic        err_flag_i = 0, dbl_flag_i = 0, blk_start_i = 0;
  logic [23:0] sample_l_i = '0, sample_r_i = '0;
  logic [1:0]  valid_i = '0, user_i = '0, chan_i = '0;
  logic bck_o, wck_o, fs128_c_o, sync_u_o, err_bs_o, dbl_v_o, sdo_o, dsp_sdo_o;

  int  errors = 0, checks = 0;
  bit  reported = 0;

  always #10 clk_i = ~clk_i;

  aud_rx_out_router i_aud_rx_out_router (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 40000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rng = 32'h1234_5678;
    logic [23:0] exp_word = '0;
    logic        e_bs = 0, e_v = 0, e_u = 0, e_c = 0;
    logic [5:0]  cfg = '0;
    logic        smute, vmute, dbit;

    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12", "bck", bck_o, 1'b0);
    chk("R12", "wck", wck_o, 1'b0);
    chk("R12", "aux", fs128_c_o, 1'b0);
    chk("R12", "sync", sync_u_o, 1'b1);
    chk("R12", "sdo", sdo_o, 1'b0);
    chk("R12", "dsp", dsp_sdo_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < 256 * 66; i++) begin
      logic [7:0] c;
      logic [4:0] b;
      c = i[7:0];
      b = c[6:2];
      dbit  = (b < 24) ? exp_word[23 - b] : 1'b0;
      smute = free_run_i | vuc_mute_i;
      chk("R1", "bck", bck_o, c[1]);
      chk("R1", "wck", wck_o, c[7]);
      // R2 R3 slot data, R4 R5 mutes
      chk("R4", "sdo", sdo_o, dbit & ~free_run_i & ~sdo_mute_i);
      chk("R5", "dsp", dsp_sdo_o, dbit & ~free_run_i);
      if (cs_mode_i) chk("R6", "chan stat (R10 R11)", fs128_c_o, e_c & ~smute);
      else           chk("R6", "aux clk", fs128_c_o, c[0]);
      if (user_mode_i) chk("R7", "user (R10 R11)", sync_u_o, e_u & ~smute);
      else             chk("R7", "sync", sync_u_o, c[7:2] == 6'd0);
      if (bs_mode_i) chk("R8", "blk start (R10 R11)", err_bs_o, e_bs & ~smute);
      else           chk("R8", "err flag", err_bs_o, err_flag_i);
      if (val_mode_i) chk("R9", "validity (R10 R11)", dbl_v_o, e_v & ~smute);
      else            chk("R9", "dbl flag", dbl_v_o, dbl_flag_i);

      // R3 R11: capture what the next slot should carry
      if (c == 8'd127) begin
        exp_word = sample_r_i; e_bs = blk_start_i;
        e_v = valid_i[1]; e_u = user_i[1]; e_c = chan_i[1];
      end else if (c == 8'd255) begin
        exp_word = sample_l_i; e_bs = blk_start_i;
        e_v = valid_i[0]; e_u = user_i[0]; e_c = chan_i[0];
      end

      if (c == 8'd200 || c == 8'd60) begin
        rng = rng * 32'd1103515245 + 32'd12345;
        sample_l_i = rng[31:8];
        rng = rng * 32'd1103515245 + 32'd12345;
        sample_r_i = rng[31:8];
        {blk_start_i, valid_i, user_i, chan_i, err_flag_i, dbl_flag_i} = rng[9:0];
      end
      if (c == 8'd200) begin
        {cs_mode_i, user_mode_i, bs_mode_i, val_mode_i} = cfg[3:0];
        sdo_mute_i = (cfg[5:4] == 2'd1);
        vuc_mute_i = (cfg[5:4] == 2'd2);
        free_run_i = (cfg[5:4] == 2'd3);
        cfg = cfg + 6'd1;
      end
      @(negedge clk_i);
    end
    report();
  end
endmodule